// File: doc/BRIEF.md
# Program Memory Block Protection Controller

This block guards a 32K-word program memory. It holds one protection word whose cells behave like one-time-programmable storage. A cell reads 1 when erased. A program operation can only turn a 1 into a 0, and only an erase of the whole word brings bits back to 1. For every access request, the block uses the stored word to decide whether the read or write at the given 15-bit address is allowed.

The word holds two flags and a boundary marker pair:

- **Global lock (bit 14).** A 0 here closes the whole memory.
- **Block lock (bit 13).** A 0 here, with the global lock at 1, closes the memory from address 0 up to a boundary.
- **Marker pair.** The 6-bit true marker `N` sets the boundary at `(N+1)*512`. The 6-bit false marker must hold the bitwise complement of `N`. Once a matching pair is programmed, the boundary cannot be moved, because any further program operation can only clear more bits and so breaks the complement relation.

Any word in which block protection is engaged but the markers do not match is treated as invalid. The block then denies every access and raises a status flag.

Programming and erase act on the clock edge that accepts the request, so the new word is visible from the next cycle. Access decisions are purely combinational from the stored word and the request.

Top module: `eprom_guard`

## Requirements
- R1: After reset, and in the cycle after any accepted erase, the stored word reads 16'hFFFF.
- R2: A program request without erase updates the stored word to (old AND data) in the next cycle. The field layout is: true marker in bits [5:0], reserved bit 6, false marker in bits [12:7], block lock at bit 13, global lock at bit 14, reserved bit 15.
- R3: When erase and program are requested in the same cycle, erase wins. The word becomes 16'hFFFF and no reserved-bit flag is raised.
- R4: A program request (without erase) whose data has a 0 in bit 6 or bit 15 is rejected. The word is left unchanged, and `rsv_reject` is high for exactly the next cycle. Otherwise `rsv_reject` is 0.
- R5: With bit 14 = 1 and bit 13 = 1, every requested address is granted.
- R6: With bit 14 = 1, bit 13 = 0 and false marker == ~true marker:
  - requests with address < (N+1)*512 are denied;
  - requests with address >= (N+1)*512 are granted.
- R7: With bit 14 = 0, every request is denied, whatever bit 13 and the markers hold.
- R8: With bit 14 = 1, bit 13 = 0 and false marker != ~true marker, every request is denied and `marker_bad` is 1. In every other case `marker_bad` is 0.
- R9: With a valid marker pair and N = 63, every address up to 0x7FFF is denied. The boundary computation does not wrap.
- R10: Exactly one of `acc_grant` and `acc_deny` is 1 in a cycle with `acc_req` = 1. Both are 0 when `acc_req` = 0. Both follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (word returns to erased state) |
| pgm_en | input | 1 | Program request: AND `pgm_data` into the word |
| pgm_data | input | 16 | Data for a program request |
| erase_en | input | 1 | Erase request: set every bit of the word to 1 |
| prot_word | output | 16 | Current stored protection word |
| rsv_reject | output | 1 | Pulses for one cycle after a rejected program request |
| marker_bad | output | 1 | Block protection engaged with a mismatched marker pair |
| acc_req | input | 1 | Access request strobe |
| acc_addr | input | 15 | Word address of the access |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |

## Verification
- **Next-cycle results.** The stored word and `rsv_reject` change one clock after the request. The bench drives each request at a falling edge, lets the rising edge capture it, and compares these outputs against its model at the following falling edge.
- **Same-cycle results.** `acc_grant`, `acc_deny` and `marker_bad` are combinational. They are compared about 1 ns after the inputs are driven at the falling edge, using the model word that is valid in that same cycle.
- **Model update.** The model advances its word only after the rising edge, so each comparison pairs the inputs with the word that was live when they were applied.

// File: rtl/eg_pkg.sv
package eg_pkg;

    localparam int ADDR_W   = 15;
    localparam int MARK_W   = 6;
    localparam int SEG_LOG2 = 9;
    localparam int LIMIT_W  = MARK_W + 1 + SEG_LOG2;
    localparam int WORD_W   = 2 * MARK_W + 4;

    // Stored word, MSB first
    typedef struct packed {
        logic              rsv_hi;
        logic              glock;
        logic              block;
        logic [MARK_W-1:0] fmark;
        logic              rsv_lo;
        logic [MARK_W-1:0] tmark;
    } pword_t;

    typedef enum logic [1:0] {
        PM_OPEN   = 2'd0,
        PM_BLOCK  = 2'd1,
        PM_ALL    = 2'd2,
        PM_BROKEN = 2'd3
    } pmode_t;

    localparam pword_t PW_ERASED = '1;

    function automatic logic rsv_cleared(input pword_t w);
        return !(w.rsv_hi && w.rsv_lo);
    endfunction

    function automatic logic markers_match(input pword_t w);
        return w.fmark == ~w.tmark;
    endfunction

    // First unprotected address, one bit wider than the address so N=63 gives 2**ADDR_W
    function automatic logic [LIMIT_W-1:0] first_open(input logic [MARK_W-1:0] tm);
        logic [MARK_W:0] seg;
        seg = {1'b0, tm} + (MARK_W+1)'(1);
        return {seg, {SEG_LOG2{1'b0}}};
    endfunction

endpackage

// File: rtl/pw_store.sv
module pw_store
    import eg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pgm_en,
    input  pword_t pgm_data,
    input  logic   erase_en,
    output pword_t word_q,
    output logic   rsv_rej_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= PW_ERASED;
            rsv_rej_q <= 1'b0;
        end else begin
            rsv_rej_q <= 1'b0;
            if (erase_en) begin
                word_q <= PW_ERASED;
            end else if (pgm_en) begin
                if (rsv_cleared(pgm_data)) begin
                    rsv_rej_q <= 1'b1;
                end else begin
                    word_q <= word_q & pgm_data;
                end
            end
        end
    end

    a_r1_erase_sets: assert property (@(posedge clk) disable iff (rst)
        erase_en |=> (word_q == PW_ERASED));

    a_r3_erase_wins: assert property (@(posedge clk) disable iff (rst)
        (erase_en && pgm_en) |=> !rsv_rej_q);

    a_r2_only_clears: assert property (@(posedge clk) disable iff (rst)
        !erase_en |=> ((word_q & ~$past(word_q)) == '0));

    a_r4_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (pgm_en && !erase_en && rsv_cleared(pgm_data)) |=> ($stable(word_q) && rsv_rej_q));

endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import eg_pkg::*;
(
    input  pword_t             word,
    output pmode_t             mode,
    output logic [LIMIT_W-1:0] limit,
    output logic               marker_bad
);

    always_comb begin
        if (!word.glock) begin
            mode = PM_ALL;
        end else if (word.block) begin
            mode = PM_OPEN;
        end else if (!markers_match(word)) begin
            mode = PM_BROKEN;
        end else begin
            mode = PM_BLOCK;
        end
        limit      = first_open(word.tmark);
        marker_bad = (mode == PM_BROKEN);
    end

endmodule

// File: rtl/access_judge.sv
module access_judge
    import eg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [ADDR_W-1:0]  addr,
    input  pmode_t             mode,
    input  logic [LIMIT_W-1:0] limit,
    output logic               grant,
    output logic               deny
);

    logic allow;

    always_comb begin
        unique case (mode)
            PM_OPEN:  allow = 1'b1;
            PM_BLOCK: allow = ({{(LIMIT_W-ADDR_W){1'b0}}, addr} >= limit);
            default:  allow = 1'b0;
        endcase
        grant = req && allow;
        deny  = req && !allow;
    end

    a_r10_one_hot: assert property (@(posedge clk) disable iff (rst)
        req |-> $onehot({grant, deny}));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req |-> !(grant || deny));

    a_r7_global_closed: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_ALL) |-> !grant);

    a_r5_open_all: assert property (@(posedge clk) disable iff (rst)
        (req && mode == PM_OPEN) |-> grant);

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_BLOCK && limit[LIMIT_W-1]) |-> !grant);

endmodule

// File: rtl/eprom_guard.sv
module eprom_guard
    import eg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_en,
    input  logic [WORD_W-1:0] pgm_data,
    input  logic              erase_en,
    output logic [WORD_W-1:0] prot_word,
    output logic              rsv_reject,
    output logic              marker_bad,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_grant,
    output logic              acc_deny
);

    pword_t             word_q;
    pmode_t             mode;
    logic [LIMIT_W-1:0] limit;

    pw_store u_store (
        .clk       (clk),
        .rst       (rst),
        .pgm_en    (pgm_en),
        .pgm_data  (pword_t'(pgm_data)),
        .erase_en  (erase_en),
        .word_q    (word_q),
        .rsv_rej_q (rsv_reject)
    );

    mode_decode u_decode (
        .word       (word_q),
        .mode       (mode),
        .limit      (limit),
        .marker_bad (marker_bad)
    );

    access_judge u_judge (
        .clk   (clk),
        .rst   (rst),
        .req   (acc_req),
        .addr  (acc_addr),
        .mode  (mode),
        .limit (limit),
        .grant (acc_grant),
        .deny  (acc_deny)
    );

    assign prot_word = word_q;

    a_r8_bad_closed: assert property (@(posedge clk) disable iff (rst)
        marker_bad |-> !acc_grant);

endmodule

// File: tb/eprom_guard_tb_top.sv
`timescale 1ns/1ps
module eprom_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pgm_en = 1'b0;
    logic [15:0] pgm_data = 16'hFFFF;
    logic        erase_en = 1'b0;
    logic [15:0] prot_word;
    logic        rsv_reject, marker_bad;
    logic        acc_req = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        acc_grant, acc_deny;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic [15:0] m_word = 16'hFFFF;
    logic        m_rej  = 1'b0;

    always #2.5 clk = ~clk;

    eprom_guard dut_i (
        .clk(clk), .rst(rst), .pgm_en(pgm_en), .pgm_data(pgm_data),
        .erase_en(erase_en), .prot_word(prot_word), .rsv_reject(rsv_reject),
        .marker_bad(marker_bad), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_grant(acc_grant), .acc_deny(acc_deny)
    );

    function automatic bit m_mismatch(input logic [15:0] w);
        return w[14] && !w[13] && (w[12:7] != ~w[5:0]);
    endfunction

    function automatic bit m_allow(input logic [15:0] w, input logic [14:0] a);
        int lim;
        if (!w[14]) return 0;
        if (w[13]) return 1;
        if (w[12:7] != ~w[5:0]) return 0;
        lim = (int'(w[5:0]) + 1) * 512;
        return int'(a) >= lim;
    endfunction

    function automatic string m_tag(input logic [15:0] w);
        if (!w[14]) return "R7";
        if (w[13]) return "R5";
        if (w[12:7] != ~w[5:0]) return "R8";
        if (w[5:0] == 6'd63) return "R9";
        return "R6";
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp_v);
        end
    endtask

    // One cycle: drive at falling edge, check mid-cycle, advance model at rising edge
    task automatic step(input string wtag, input bit pg, input logic [15:0] d,
                        input bit er, input bit rq, input logic [14:0] a);
        bit ex;
        @(negedge clk);
        pgm_en = pg; pgm_data = d; erase_en = er; acc_req = rq; acc_addr = a;
        #1;
        chk(wtag, "word", int'(prot_word), int'(m_word));
        chk("R4", "rsv_reject", int'(rsv_reject), int'(m_rej));
        chk("R8", "marker_bad", int'(marker_bad), int'(m_mismatch(m_word)));
        ex = rq && m_allow(m_word, a);
        chk(rq ? m_tag(m_word) : "R10", "grant", int'(acc_grant), int'(ex));
        chk(rq ? m_tag(m_word) : "R10", "deny", int'(acc_deny), int'(rq && !ex));
        @(posedge clk);
        m_rej = 1'b0;
        if (er) m_word = 16'hFFFF;
        else if (pg) begin
            if (!(d[15] && d[6])) m_rej = 1'b1;
            else m_word = m_word & d;
        end
    endtask

    function automatic logic [15:0] mk(input bit gl, input bit bl, input logic [5:0] fm,
                                       input logic [5:0] tm);
        return {1'b1, gl, bl, fm, 1'b1, tm};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state, R5 open sweep
        step("R1", 0, 16'hFFFF, 0, 1, 15'h0000);
        step("R1", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        step("R10", 0, 16'hFFFF, 0, 0, 15'h1234);
        // R2 valid block boundary N=5 -> 3072
        step("R2", 1, mk(1, 0, ~6'd5, 6'd5), 0, 1, 15'h0100);
        step("R2", 0, 16'hFFFF, 0, 1, 15'd3071);
        step("R6", 0, 16'hFFFF, 0, 1, 15'd3072);
        step("R6", 0, 16'hFFFF, 0, 1, 15'd0);
        step("R6", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        step("R10", 0, 16'hFFFF, 0, 0, 15'd0);
        // R2/R8 attempt to move boundary: clearing more TM bits breaks parity
        step("R2", 1, mk(1, 1, 6'h3F, 6'd4), 0, 1, 15'd3072);
        step("R8", 0, 16'hFFFF, 0, 1, 15'd3072);
        step("R8", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        // R4 reserved bits
        step("R4", 1, 16'h7FFF, 0, 1, 15'h7FFF);
        step("R4", 1, 16'hFFBF, 0, 1, 15'h7FFF);
        step("R4", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        // R1 erase
        step("R1", 0, 16'hFFFF, 1, 1, 15'h7FFF);
        step("R1", 0, 16'hFFFF, 0, 1, 15'h0000);
        // R9 N=63
        step("R9", 1, mk(1, 0, 6'd0, 6'd63), 0, 1, 15'h7FFF);
        step("R9", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        step("R9", 0, 16'hFFFF, 0, 1, 15'h7E00);
        // R6 N=0 boundary 512
        step("R1", 0, 16'hFFFF, 1, 0, 15'd0);
        step("R6", 1, mk(1, 0, 6'h3F, 6'd0), 0, 1, 15'd511);
        step("R6", 0, 16'hFFFF, 0, 1, 15'd511);
        step("R6", 0, 16'hFFFF, 0, 1, 15'd512);
        // R7 global lock with block bit 1 and 0
        step("R7", 1, mk(0, 1, 6'h3F, 6'h3F), 0, 1, 15'h7FFF);
        step("R7", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        step("R7", 1, mk(1, 0, 6'h3F, 6'h3F), 0, 1, 15'h0000);
        step("R7", 0, 16'hFFFF, 0, 1, 15'h7FFF);
        // R3 erase beats program, including reserved violation
        step("R3", 1, 16'h0000, 1, 1, 15'h4000);
        step("R3", 0, 16'hFFFF, 0, 1, 15'h4000);
        // sweep several N values
        for (int n = 1; n < 63; n += 13) begin
            step("R1", 0, 16'hFFFF, 1, 0, 15'd0);
            step("R2", 1, mk(1, 0, ~6'(n), 6'(n)), 0, 0, 15'd0);
            step("R6", 0, 16'hFFFF, 0, 1, 15'((n + 1) * 512 - 1));
            step("R6", 0, 16'hFFFF, 0, 1, 15'((n + 1) * 512));
        end
        step("R1", 0, 16'hFFFF, 0, 0, 15'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule